// File: doc/BRIEF.md
# Digital Three-Phase Vector Rotator

The block turns sampled, signed phase quantities into a rotating frame set by a 12-bit digital angle. A two-bit format select picks one of three input arrangements: an orthogonal pair fed straight through, three phases spaced 120 degrees apart, or only the second and third phases with the first one rebuilt as the negative of their sum. The three-to-two phase (Clarke) stage scales the direct axis by 2/3 and the quadrature axis by 1/sqrt(3). Its orthogonal result is presented unrotated, then rotated by the loaded angle, and finally re-expanded into a rotated three-phase set.

A new angle is captured on a rising edge of the strobe. The following falling edge starts a conversion, and busy stays high for a parameterised number of clock cycles. Sine and cosine come from a combinational quarter-wave polynomial. They are written into their coefficient registers together on the last busy cycle, so the rotation never mixes two angles. A reverse control, captured with the angle, flips the sign of the sine term so that the block applies the inverse rotation. Phase inputs are processed continuously, so the rotated outputs follow the analogue-rate samples with a fixed pipeline delay.

Top module: `vector_rotator`

## Requirements
- R1: The angle is unsigned, with angle_i[11] as MSB and a full turn equal to 4096 codes. It is captured only on a clock where strobe_i is seen rising. Changes to angle_i while strobe_i stays high do not affect the result.
- R2: busy_o rises one clock after a falling edge of strobe_i is sampled, provided that an accepted rising edge preceded it. It then stays high for exactly CONV_CYCLES clocks.
- R3: The sine and cosine coefficients change together, and only on the clock where busy_o falls. While busy_o is high, the rotated outputs still use the previous angle.
- R4: A strobe rising edge seen while busy_o is high is ignored. It neither changes the angle nor starts another conversion, and it sets overrun_o, which then stays high until reset.
- R5: mode_i codes select the format. 2'b01 and 2'b00 give d = ph_a_i and q = ph_quad_i. 2'b10 gives d = (2a-b-c)/3 and q = (c-b)/sqrt(3). 2'b11 uses the same formulas with a replaced by -(b+c). Inputs that the selected format does not use have no effect on any output.
- R6: The rotated pair is rot_d_o = d*cos(t) - q*sin(t) and rot_q_o = d*sin(t) + q*cos(t), with t = 2*pi*angle/4096, within 6 LSB.
- R7: The three-phase outputs are rot_d_o, -rot_d/2 - (sqrt(3)/2)*rot_q, and -rot_d/2 + (sqrt(3)/2)*rot_q, within 8 LSB. For balanced inputs these equal cos(phi+t), cos(phi+t+120) and cos(phi+t+240).
- R8: With reverse_i high at capture, the sine term is negated, which gives a rotation by -t.
- R9: All outputs are 16-bit two's complement and saturate at 32767 and -32768 instead of wrapping.
- R10: After reset, busy_o and overrun_o are low, the outputs are zero and the coefficients hold the angle-zero values. An orthogonal input therefore passes through the rotation within 1 LSB.
- R11: The unrotated pair reflects the phase inputs one clock later. The rotated pair and the three-phase set reflect them two clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | Angle load strobe; rise captures, fall starts conversion |
| angle_i | input | 12 | Rotation angle, unsigned, full turn |
| reverse_i | input | 1 | Selects inverse rotation, captured with the angle |
| mode_i | input | 2 | Input format select |
| ph_a_i | input | 16 | Phase at 0 degrees, or direct axis in orthogonal mode |
| ph_b_i | input | 16 | Phase at 120 degrees |
| ph_c_i | input | 16 | Phase at 240 degrees |
| ph_quad_i | input | 16 | Quadrature axis in orthogonal mode |
| busy_o | output | 1 | Conversion in progress |
| overrun_o | output | 1 | Sticky flag for a strobe arriving while busy |
| clk_d_o | output | 16 | Unrotated direct component |
| clk_q_o | output | 16 | Unrotated quadrature component |
| rot_d_o | output | 16 | Rotated direct component |
| rot_q_o | output | 16 | Rotated quadrature component |
| rot_a_o | output | 16 | Rotated phase at 0 degrees |
| rot_b_o | output | 16 | Rotated phase at 120 degrees |
| rot_c_o | output | 16 | Rotated phase at 240 degrees |

## Verification
The handshake assertions assume that strobe_i is a synchronous level that stays high for at least one full clock. They also assume that a falling edge follows each accepted rising edge before the next one, and that reset is the only thing that clears the sticky flag. The orthogonal-bypass assertion assumes that mode_i and the phase inputs are ordinary clocked levels. The stimulus drives every input on the falling clock edge and shapes strobe pulses in whole cycles. It waits for busy_o to drop before it judges any rotated value, and it deliberately sends an extra strobe pulse inside a busy window only to exercise the overrun path.

// File: rtl/vrot_pkg.sv
package vrot_pkg;
  typedef enum logic [1:0] {
    MODE_ORTH_ALT = 2'b00,
    MODE_ORTH     = 2'b01,
    MODE_THREE    = 2'b10,
    MODE_TWO      = 2'b11
  } vrot_mode_e;
endpackage

// File: rtl/vrot_trig.sv
module vrot_trig #(
  parameter int ANG_W  = 12,
  parameter int COEF_W = 16
) (
  input  logic [ANG_W-1:0]         angle_i,
  output logic signed [COEF_W-1:0] sin_o,
  output logic signed [COEF_W-1:0] cos_o
);
  localparam int QB   = ANG_W - 2;
  localparam int FRAC = 20;
  localparam int SH   = FRAC - COEF_W + 1;
  localparam longint CMAX = (64'sd1 <<< (COEF_W - 1)) - 1;
  // odd polynomial for sin(pi/2 * x), x in [0,1], Q20
  localparam longint C1 = 64'sd1647102;
  localparam longint C3 = 64'sd677297;
  localparam longint C5 = 64'sd83349;
  localparam longint C7 = 64'sd4574;

  function automatic logic signed [COEF_W-1:0] qsin(input logic [QB:0] v);
    logic signed [63:0] x, x2, p, s;
    x  = $signed(64'(v)) <<< (FRAC - QB);
    x2 = (x * x) >>> FRAC;
    p  = C7;
    p  = C5 - ((x2 * p) >>> FRAC);
    p  = C3 - ((x2 * p) >>> FRAC);
    p  = C1 - ((x2 * p) >>> FRAC);
    s  = ((x * p) >>> FRAC) + (64'sd1 <<< (SH - 1));
    s  = s >>> SH;
    if (s > CMAX) s = CMAX;
    if (s < 0) s = 0;
    return COEF_W'(s);
  endfunction

  logic [1:0]              quad;
  logic [QB:0]             u, w;
  logic signed [COEF_W-1:0] su, sw;

  always_comb begin
    quad = angle_i[ANG_W-1 -: 2];
    u    = {1'b0, angle_i[QB-1:0]};
    w    = (QB+1)'(1 << QB) - u;
    su   = qsin(u);
    sw   = qsin(w);
    unique case (quad)
      2'd0:    begin sin_o = su;  cos_o = sw;  end
      2'd1:    begin sin_o = sw;  cos_o = -su; end
      2'd2:    begin sin_o = -su; cos_o = -sw; end
      default: begin sin_o = -sw; cos_o = su;  end
    endcase
  end
endmodule

// File: rtl/vrot_ctrl.sv
module vrot_ctrl #(
  parameter int ANG_W       = 12,
  parameter int COEF_W      = 16,
  parameter int CONV_CYCLES = 200
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     strobe_i,
  input  logic [ANG_W-1:0]         angle_i,
  input  logic                     reverse_i,
  input  logic signed [COEF_W-1:0] trig_sin_i,
  input  logic signed [COEF_W-1:0] trig_cos_i,
  output logic [ANG_W-1:0]         angle_o,
  output logic                     busy_o,
  output logic                     overrun_o,
  output logic signed [COEF_W-1:0] sin_o,
  output logic signed [COEF_W-1:0] cos_o
);
  localparam int CNT_W = $clog2(CONV_CYCLES + 1);
  localparam logic signed [COEF_W-1:0] CMAX = {1'b0, {(COEF_W-1){1'b1}}};

  logic             strobe_q, armed_q, rev_q, busy_q, ovr_q;
  logic [ANG_W-1:0] angle_q;
  logic [CNT_W-1:0] cnt_q;
  logic signed [COEF_W-1:0] sin_q, cos_q;
  logic rise, fall;

  assign rise = strobe_i & ~strobe_q;
  assign fall = ~strobe_i & strobe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strobe_q <= 1'b0;
      armed_q  <= 1'b0;
      rev_q    <= 1'b0;
      busy_q   <= 1'b0;
      ovr_q    <= 1'b0;
      angle_q  <= '0;
      cnt_q    <= '0;
      sin_q    <= '0;
      cos_q    <= CMAX;
    end else begin
      strobe_q <= strobe_i;
      if (rise) begin
        if (busy_q) ovr_q <= 1'b1;
        else begin
          angle_q <= angle_i;
          rev_q   <= reverse_i;
          armed_q <= 1'b1;
        end
      end
      if (busy_q) begin
        if (cnt_q == '0) begin
          busy_q <= 1'b0;
          cos_q  <= trig_cos_i;
          sin_q  <= rev_q ? -trig_sin_i : trig_sin_i;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end else if (fall && armed_q) begin
        busy_q  <= 1'b1;
        armed_q <= 1'b0;
        cnt_q   <= CNT_W'(CONV_CYCLES - 1);
      end
    end
  end

  assign angle_o   = angle_q;
  assign busy_o    = busy_q;
  assign overrun_o = ovr_q;
  assign sin_o     = sin_q;
  assign cos_o     = cos_q;

  // observed busy run length, used only by the checks below
  logic [CNT_W-1:0] run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= '0;
    else if (busy_q) run_q <= run_q + 1'b1;
    else run_q <= '0;
  end

  a_r2_busy_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> ($past(strobe_q) && !$past(strobe_i)));
  a_r2_busy_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> (run_q == CNT_W'(CONV_CYCLES)));
  a_r2_busy_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (run_q < CNT_W'(CONV_CYCLES)));
  a_r3_coef_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(busy_q) |-> ($stable(cos_q) && $stable(sin_q)));
  a_r1_angle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> $stable(angle_q));
  a_r4_overrun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_q |=> ovr_q);
endmodule

// File: rtl/vrot_clarke.sv
module vrot_clarke
  import vrot_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [1:0]           mode_i,
  input  logic signed [DW-1:0] ph_a_i,
  input  logic signed [DW-1:0] ph_b_i,
  input  logic signed [DW-1:0] ph_c_i,
  input  logic signed [DW-1:0] ph_q_i,
  output logic signed [DW-1:0] d_o,
  output logic signed [DW-1:0] q_o
);
  localparam longint SMAX   = (64'sd1 <<< (DW - 1)) - 1;
  localparam longint SMIN   = -(64'sd1 <<< (DW - 1));
  localparam longint K_3RD  = 64'sd21845;  // 1/3 in Q16
  localparam longint K_RT3  = 64'sd37837;  // 1/sqrt(3) in Q16
  localparam longint RND16  = 64'sd32768;

  function automatic logic signed [DW-1:0] sat(input logic signed [63:0] v);
    if (v > SMAX) return DW'(SMAX);
    else if (v < SMIN) return DW'(SMIN);
    else return DW'(v);
  endfunction

  vrot_mode_e md;
  logic signed [63:0] a, b, c, a_eff, dn, qn;
  logic signed [DW-1:0] d_n, q_n, d_q, q_q;

  always_comb begin
    md    = vrot_mode_e'(mode_i);
    a     = 64'(ph_a_i);
    b     = 64'(ph_b_i);
    c     = 64'(ph_c_i);
    a_eff = (md == MODE_TWO) ? -(b + c) : a;
    dn    = (((a_eff <<< 1) - b - c) * K_3RD + RND16) >>> 16;
    qn    = ((c - b) * K_RT3 + RND16) >>> 16;
    if (md == MODE_ORTH || md == MODE_ORTH_ALT) begin
      d_n = ph_a_i;
      q_n = ph_q_i;
    end else begin
      d_n = sat(dn);
      q_n = sat(qn);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d_q <= '0;
      q_q <= '0;
    end else begin
      d_q <= d_n;
      q_q <= q_n;
    end
  end

  assign d_o = d_q;
  assign q_o = q_q;

  a_r5_orth_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[1] == 1'b0) |=> ((d_q == $past(ph_a_i)) && (q_q == $past(ph_q_i))));
endmodule

// File: rtl/vrot_rotate.sv
module vrot_rotate #(
  parameter int DW = 16,
  parameter int CW = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic signed [DW-1:0] d_i,
  input  logic signed [DW-1:0] q_i,
  input  logic signed [CW-1:0] sin_i,
  input  logic signed [CW-1:0] cos_i,
  output logic signed [DW-1:0] rd_o,
  output logic signed [DW-1:0] rq_o,
  output logic signed [DW-1:0] pa_o,
  output logic signed [DW-1:0] pb_o,
  output logic signed [DW-1:0] pc_o
);
  localparam longint SMAX  = (64'sd1 <<< (DW - 1)) - 1;
  localparam longint SMIN  = -(64'sd1 <<< (DW - 1));
  localparam longint RNDC  = 64'sd1 <<< (CW - 2);
  localparam longint K_HRT = 64'sd56756;  // sqrt(3)/2 in Q16
  localparam longint RND16 = 64'sd32768;

  function automatic logic signed [DW-1:0] sat(input logic signed [63:0] v);
    if (v > SMAX) return DW'(SMAX);
    else if (v < SMIN) return DW'(SMIN);
    else return DW'(v);
  endfunction

  logic signed [63:0] d, q, s, c, rdw, rqw, rdl, rql, pbw, pcw;
  logic signed [DW-1:0] rd_n, rq_n, pb_n, pc_n;
  logic signed [DW-1:0] rd_q, rq_q, pa_q, pb_q, pc_q;

  always_comb begin
    d    = 64'(d_i);
    q    = 64'(q_i);
    s    = 64'(sin_i);
    c    = 64'(cos_i);
    rdw  = (d * c - q * s + RNDC) >>> (CW - 1);
    rqw  = (d * s + q * c + RNDC) >>> (CW - 1);
    rd_n = sat(rdw);
    rq_n = sat(rqw);
    rdl  = 64'(rd_n);
    rql  = 64'(rq_n);
    pbw  = (-(rdl <<< 15) - rql * K_HRT + RND16) >>> 16;
    pcw  = (-(rdl <<< 15) + rql * K_HRT + RND16) >>> 16;
    pb_n = sat(pbw);
    pc_n = sat(pcw);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q <= '0;
      rq_q <= '0;
      pa_q <= '0;
      pb_q <= '0;
      pc_q <= '0;
    end else begin
      rd_q <= rd_n;
      rq_q <= rq_n;
      pa_q <= rd_n;
      pb_q <= pb_n;
      pc_q <= pc_n;
    end
  end

  assign rd_o = rd_q;
  assign rq_o = rq_q;
  assign pa_o = pa_q;
  assign pb_o = pb_q;
  assign pc_o = pc_q;

  // zero input vector must give zero rotated vector for any coefficients
  a_r6_zero_in: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_i == '0 && q_i == '0) |=> (rd_q == '0 && rq_q == '0));
endmodule

// File: rtl/vector_rotator.sv
module vector_rotator #(
  parameter int ANG_W       = 12,
  parameter int DW          = 16,
  parameter int CW          = 16,
  parameter int CONV_CYCLES = 200
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 strobe_i,
  input  logic [ANG_W-1:0]     angle_i,
  input  logic                 reverse_i,
  input  logic [1:0]           mode_i,
  input  logic signed [DW-1:0] ph_a_i,
  input  logic signed [DW-1:0] ph_b_i,
  input  logic signed [DW-1:0] ph_c_i,
  input  logic signed [DW-1:0] ph_quad_i,
  output logic                 busy_o,
  output logic                 overrun_o,
  output logic signed [DW-1:0] clk_d_o,
  output logic signed [DW-1:0] clk_q_o,
  output logic signed [DW-1:0] rot_d_o,
  output logic signed [DW-1:0] rot_q_o,
  output logic signed [DW-1:0] rot_a_o,
  output logic signed [DW-1:0] rot_b_o,
  output logic signed [DW-1:0] rot_c_o
);
  logic [ANG_W-1:0]     angle_l;
  logic signed [CW-1:0] trig_sin, trig_cos, coef_sin, coef_cos;
  logic signed [DW-1:0] cd, cq;

  vrot_trig #(.ANG_W(ANG_W), .COEF_W(CW)) u_trig (
    .angle_i (angle_l),
    .sin_o   (trig_sin),
    .cos_o   (trig_cos)
  );

  vrot_ctrl #(.ANG_W(ANG_W), .COEF_W(CW), .CONV_CYCLES(CONV_CYCLES)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .strobe_i   (strobe_i),
    .angle_i    (angle_i),
    .reverse_i  (reverse_i),
    .trig_sin_i (trig_sin),
    .trig_cos_i (trig_cos),
    .angle_o    (angle_l),
    .busy_o     (busy_o),
    .overrun_o  (overrun_o),
    .sin_o      (coef_sin),
    .cos_o      (coef_cos)
  );

  vrot_clarke #(.DW(DW)) u_clarke (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode_i),
    .ph_a_i (ph_a_i),
    .ph_b_i (ph_b_i),
    .ph_c_i (ph_c_i),
    .ph_q_i (ph_quad_i),
    .d_o    (cd),
    .q_o    (cq)
  );

  vrot_rotate #(.DW(DW), .CW(CW)) u_rotate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (cd),
    .q_i    (cq),
    .sin_i  (coef_sin),
    .cos_i  (coef_cos),
    .rd_o   (rot_d_o),
    .rq_o   (rot_q_o),
    .pa_o   (rot_a_o),
    .pb_o   (rot_b_o),
    .pc_o   (rot_c_o)
  );

  assign clk_d_o = cd;
  assign clk_q_o = cq;
endmodule

// File: tb/vector_rotator_bench.sv
module vector_rotator_bench;
  localparam int CONV = 8;
  localparam real PI = 3.14159265358979;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strobe = 1'b0;
  logic [11:0] angle = '0;
  logic rev = 1'b0;
  logic [1:0] mode = 2'b01;
  logic signed [15:0] pa = '0, pb = '0, pc = '0, pq = '0;
  logic busy, ovr;
  logic signed [15:0] cd, cq, rd, rq, ra, rb, rc;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  vector_rotator #(.CONV_CYCLES(CONV)) u_vector_rotator (
    .clk_i(clk), .rst_ni(rst_n), .strobe_i(strobe), .angle_i(angle),
    .reverse_i(rev), .mode_i(mode), .ph_a_i(pa), .ph_b_i(pb), .ph_c_i(pc),
    .ph_quad_i(pq), .busy_o(busy), .overrun_o(ovr), .clk_d_o(cd), .clk_q_o(cq),
    .rot_d_o(rd), .rot_q_o(rq), .rot_a_o(ra), .rot_b_o(rb), .rot_c_o(rc)
  );

  function automatic real clampr(input real v);
    if (v > 32767.0) return 32767.0;
    if (v < -32768.0) return -32768.0;
    return v;
  endfunction

  task automatic chk(input string req, input int act, input real exp, input int tol);
    real diff;
    checks++;
    diff = act - exp;
    if (diff < 0.0) diff = -diff;
    if (diff > tol) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0.2f", req, act, exp);
    end
  endtask

  real e_d, e_q, e_rd, e_rq, e_pa, e_pb, e_pc;

  task automatic ref_model(input int md, input int a, input int b, input int c,
                           input int qv, input int ang, input bit rv);
    real th, s, co, aa, r3;
    r3 = $sqrt(3.0);
    if (md < 2) begin
      e_d = a; e_q = qv;
    end else begin
      aa  = (md == 3) ? -(b + c) : a;
      e_d = (2.0 * aa - b - c) / 3.0;
      e_q = (c - b) / r3;
    end
    e_d  = clampr(e_d);
    e_q  = clampr(e_q);
    th   = 2.0 * PI * ang / 4096.0;
    s    = $sin(th);
    if (rv) s = -s;
    co   = $cos(th);
    e_rd = clampr(e_d * co - e_q * s);
    e_rq = clampr(e_d * s + e_q * co);
    e_pa = e_rd;
    e_pb = clampr(-e_rd / 2.0 - r3 / 2.0 * e_rq);
    e_pc = clampr(-e_rd / 2.0 + r3 / 2.0 * e_rq);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic convert(input int ang, input bit rv);
    @(negedge clk); angle = 12'(ang); rev = rv; strobe = 1'b1;
    @(negedge clk); strobe = 1'b0;
    @(negedge clk);
    wait_idle();
    repeat (2) @(negedge clk);
  endtask

  task automatic check_all(input string rq_tag, input int md, input int a, input int b,
                           input int c, input int qv, input int ang, input bit rv);
    ref_model(md, a, b, c, qv, ang, rv);
    chk("R5 clarke d", int'(cd), e_d, 2);
    chk("R5 clarke q", int'(cq), e_q, 2);
    chk({rq_tag, " rot d"}, int'(rd), e_rd, 6);
    chk({rq_tag, " rot q"}, int'(rq), e_rq, 6);
    chk("R7 phase a", int'(ra), e_pa, 8);
    chk("R7 phase b", int'(rb), e_pb, 8);
    chk("R7 phase c", int'(rc), e_pc, 8);
  endtask

  task automatic set_in(input int md, input int a, input int b, input int c, input int qv);
    @(negedge clk);
    mode = 2'(md); pa = 16'(a); pb = 16'(b); pc = 16'(c); pq = 16'(qv);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int busy_cnt;
    int a, b, c, qv, ang;
    real phi;
    bit rv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 busy", int'(busy), 0.0, 0);
    chk("R10 overrun", int'(ovr), 0.0, 0);
    chk("R10 rot d", int'(rd), 0.0, 0);
    chk("R10 phase c", int'(rc), 0.0, 0);

    // R11 latency and R10 identity at angle zero
    mode = 2'b01; pa = 16'sd5000; pq = -16'sd3000;
    @(negedge clk);
    chk("R11 clarke d after 1", int'(cd), 5000.0, 0);
    chk("R11 rot d still old", int'(rd), 0.0, 0);
    @(negedge clk);
    chk("R11 rot d after 2", int'(rd), 5000.0, 1);
    chk("R10 identity q", int'(rq), -3000.0, 1);

    // R2 busy timing
    @(negedge clk); angle = 12'd1024; rev = 1'b0; strobe = 1'b1;
    @(negedge clk); strobe = 1'b0;
    chk("R2 busy low before fall seen", int'(busy), 0.0, 0);
    @(negedge clk);
    chk("R2 busy rises", int'(busy), 1.0, 0);
    busy_cnt = 0;
    while (busy) begin busy_cnt++; @(negedge clk); end
    chk("R2 busy length", busy_cnt, real'(CONV), 0);
    repeat (2) @(negedge clk);
    check_all("R6", 1, 5000, 0, 0, -3000, 1024, 1'b0);

    // R3 old angle used during busy
    set_in(1, 20000, 0, 0, 0);
    @(negedge clk); angle = 12'd2048; strobe = 1'b1;
    @(negedge clk); strobe = 1'b0;
    repeat (4) @(negedge clk);
    chk("R3 busy mid", int'(busy), 1.0, 0);
    ref_model(1, 20000, 0, 0, 0, 1024, 1'b0);
    chk("R3 old rot d", int'(rd), e_rd, 6);
    chk("R3 old rot q", int'(rq), e_rq, 6);
    wait_idle();
    repeat (2) @(negedge clk);
    ref_model(1, 20000, 0, 0, 0, 2048, 1'b0);
    chk("R3 new rot d", int'(rd), e_rd, 6);

    // R1 angle change while strobe high ignored
    @(negedge clk); angle = 12'd512; strobe = 1'b1;
    @(negedge clk); angle = 12'd3000;
    @(negedge clk); strobe = 1'b0;
    @(negedge clk);
    wait_idle();
    repeat (2) @(negedge clk);
    check_all("R1", 1, 20000, 0, 0, 0, 512, 1'b0);

    // R4 overrun
    chk("R4 overrun clear", int'(ovr), 0.0, 0);
    @(negedge clk); angle = 12'd1024; strobe = 1'b1;
    @(negedge clk); strobe = 1'b0;
    repeat (3) @(negedge clk);
    angle = 12'd3000; strobe = 1'b1;
    @(negedge clk); strobe = 1'b0;
    wait_idle();
    repeat (4) @(negedge clk);
    chk("R4 no restart", int'(busy), 0.0, 0);
    chk("R4 overrun set", int'(ovr), 1.0, 0);
    check_all("R4", 1, 20000, 0, 0, 0, 1024, 1'b0);
    repeat (3) @(negedge clk);
    chk("R4 overrun sticky", int'(ovr), 1.0, 0);

    // R9 saturation
    convert(512, 1'b0);
    set_in(1, 32767, 0, 0, 32767);
    chk("R9 pos sat", int'(rq), 32767.0, 0);
    set_in(1, -32768, 0, 0, -32768);
    chk("R9 neg sat", int'(rq), -32768.0, 0);
    convert(1024, 1'b0);
    set_in(1, 32767, 0, 0, 32767);
    chk("R9 three-phase sat", int'(rc), 32767.0, 0);

    // R5 reserved code behaves as orthogonal
    set_in(0, 12000, -30000, 29000, -7000);
    check_all("R5", 0, 12000, -30000, 29000, -7000, 1024, 1'b0);

    // sweep angles, all formats, both directions
    for (int i = 0; i < 256; i++) begin
      ang = i * 16 + (i % 16);
      rv  = i[0];
      convert(ang, rv);
      for (int m = 1; m < 4; m++) begin
        phi = i * 0.37 + m;
        if (m == 1) begin
          a = int'(20000.0 * $cos(phi)); qv = int'(20000.0 * $sin(phi));
          b = -30000; c = 29000;
        end else begin
          a  = (m == 3) ? -31000 : int'(20000.0 * $cos(phi));
          b  = int'(20000.0 * $cos(phi + 2.0 * PI / 3.0));
          c  = int'(20000.0 * $cos(phi + 4.0 * PI / 3.0));
          qv = 12345;
        end
        set_in(m, a, b, c, qv);
        check_all(rv ? "R8" : "R6", m, a, b, c, qv, ang, rv);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule